// File: doc/BRIEF.md
# Word Atomic Memory Operation Unit

This block executes the word-sized atomic instructions of a RISC-V hart: load-reserved, store-conditional and the nine read-modify-write operations. It takes an operation code, a word address (the rs1 value) and an operand (the rs2 value). It talks to a 32-bit memory port that may refuse any access with an error. It returns either the value for rd or an exception cause. It also holds the hart's single reservation flag. Reservation addresses are not compared, and the ordering bits are not handled.

Each operation is carried through a four-state machine. The states are ST_IDLE, ST_READ, ST_WRITE and ST_DONE.
- In ST_IDLE an accepted request goes to one of three places. It goes to ST_DONE directly on an illegal code, a misaligned address or a store-conditional with no reservation. It goes to ST_WRITE on a store-conditional that holds a reservation. It goes to ST_READ on a load-reserved or a read-modify-write.
- ST_READ waits for the read response. It goes to ST_DONE on an error or on a load-reserved. It goes to ST_WRITE for a read-modify-write, carrying the computed new word.
- ST_WRITE waits for the write response and then goes to ST_DONE.
- ST_DONE shows the result for one cycle and returns to ST_IDLE.

The memory request is held high until its response arrives. The read and the write are always two separate bus transactions.

Top module: `amo_unit`

## Requirements
- R1: An address with either of bits [1:0] set is misaligned. A load-reserved (code 0) then ends with cause 4. A store-conditional or a read-modify-write (codes 1 to 10) ends with cause 6. No bus access is made and rd is not written.
- R2: Codes 11 to 15 end with cause 2 (illegal instruction), whatever the address. No bus access is made.
- R3: A load-reserved makes one read. On success it returns the word to rd and sets the reservation flag. On a read error it ends with cause 5, leaves the flag unchanged and does not write rd.
- R4: A store-conditional with the flag set clears the flag and writes the rs2 value in one write. On success it returns 0. If the write is refused it ends with cause 7 and rd is not written; the flag stays cleared.
- R5: A store-conditional with the flag clear makes no bus access, writes nothing and returns 1.
- R6: A read-modify-write returns the old word to rd and writes back f(old, rs2). The codes are: 2 swap (rs2), 3 add, 4 xor, 5 and, 6 or, 7 signed min, 8 signed max, 9 unsigned min, 10 unsigned max.
- R7: A read error on a read-modify-write ends with cause 7 (store access fault), not 5. No write is made and rd is not written.
- R8: A write error on a read-modify-write ends with cause 7 and cancels the rd write.
- R9: The read and the write are separate transactions, and mem_we is high only during the write. Each accepted request gives exactly one done_valid pulse, one cycle long.
- R10: req_valid is ignored while busy is high.
- R11: After reset the unit is idle, with the reservation flag clear and no memory request or done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken only when not busy) |
| req_op | input | 4 | Operation code, encoding in R1, R2 and R6 |
| req_addr | input | 32 | Word address (rs1 value) |
| req_data | input | 32 | Operand (rs2 value) |
| busy | output | 1 | An operation is in progress |
| mem_req | output | 1 | Memory request, held until the response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | One-cycle response to the current request |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_err | input | 1 | Response is an error |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rd_we | output | 1 | rd is to be written |
| done_rd_data | output | 32 | Value for rd |
| done_exc | output | 1 | Operation raised an exception |
| done_cause | output | 4 | Exception cause code |
| resv_valid | output | 1 | Reservation flag |

## Verification
Every one of the sixteen operation codes is run against six address kinds:
- an aligned word in normal memory,
- the three misaligned offsets,
- a region where every access errors,
- a region that can be read but refuses writes.

These runs use four operand patterns and rotating memory words, at three response latencies. The patterns sit on the signed/unsigned boundary (0x7fffffff, 0x80000000, 0xffffffff) next to a small positive value, so signed and unsigned min/max give different answers. The two error regions separate a read fault from a write fault, which shows the cause mapping and the suppression of rd. Since each load-reserved in the sweep is followed by a store-conditional, both reservation states are reached. Counting reads and writes per operation shows the bus sequencing. A request pulsed mid-operation shows that input is ignored while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int OP_W    = 4;
    localparam int CAUSE_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LR   = 4'd0,
        OP_SC   = 4'd1,
        OP_SWAP = 4'd2,
        OP_ADD  = 4'd3,
        OP_XOR  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAXU = 4'd10
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } amo_state_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISAL = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISAL = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 4'd7;

endpackage

// File: rtl/amo_alu.sv
// Combines the old memory word with the operand for a read-modify-write.
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] result
);

    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(old_word) < $signed(operand);
    assign lt_unsigned = old_word < operand;

    always_comb begin
        unique case (op)
            OP_ADD:  result = old_word + operand;
            OP_XOR:  result = old_word ^ operand;
            OP_AND:  result = old_word & operand;
            OP_OR:   result = old_word | operand;
            OP_MIN:  result = lt_signed   ? old_word : operand;
            OP_MAX:  result = lt_signed   ? operand  : old_word;
            OP_MINU: result = lt_unsigned ? old_word : operand;
            OP_MAXU: result = lt_unsigned ? operand  : old_word;
            default: result = operand;
        endcase
    end

endmodule

// File: rtl/amo_check.sv
// Classifies a request: legality, alignment and operation class.
module amo_check
    import amo_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic [OP_W-1:0]       op,
    input  logic [ALIGN_BITS-1:0] addr_lo,
    output logic                  exc,
    output logic [CAUSE_W-1:0]    cause,
    output logic                  is_sc
);

    logic legal;
    logic misaligned;

    assign legal      = op <= OP_MAXU;
    assign misaligned = |addr_lo;
    assign is_sc      = op == OP_SC;

    always_comb begin
        exc   = 1'b0;
        cause = CAUSE_NONE;
        if (!legal) begin
            exc   = 1'b1;
            cause = CAUSE_ILLEGAL;
        end else if (misaligned) begin
            exc   = 1'b1;
            cause = (op == OP_LR) ? CAUSE_LD_MISAL : CAUSE_ST_MISAL;
        end
    end

endmodule

// File: rtl/amo_resv.sv
// The hart's single reservation flag.
module amo_resv (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic valid_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end else if (set_i) begin
            valid_o <= 1'b1;
        end
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [3:0]      req_op,
    input  logic [XLEN-1:0] req_addr,
    input  logic [XLEN-1:0] req_data,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_err,
    output logic            done_valid,
    output logic            done_rd_we,
    output logic [XLEN-1:0] done_rd_data,
    output logic            done_exc,
    output logic [3:0]      done_cause,
    output logic            resv_valid
);

    localparam int ALIGN_BITS = $clog2(XLEN / 8);

    amo_state_e state_q;
    amo_state_e state_d;

    logic [OP_W-1:0]    op_q;
    logic [XLEN-1:0]    addr_q;
    logic [XLEN-1:0]    opnd_q;
    logic [XLEN-1:0]    wdata_q;
    logic [XLEN-1:0]    rd_q;
    logic               rd_we_q;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;

    logic               accept;
    logic               chk_exc;
    logic [CAUSE_W-1:0] chk_cause;
    logic               chk_sc;
    logic [XLEN-1:0]    alu_result;
    logic               resv_set;
    logic               resv_clr;
    logic               op_is_lr;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign op_is_lr = op_q == OP_LR;

    amo_check #(
        .ALIGN_BITS(ALIGN_BITS)
    ) check_i (
        .op      (req_op),
        .addr_lo (req_addr[ALIGN_BITS-1:0]),
        .exc     (chk_exc),
        .cause   (chk_cause),
        .is_sc   (chk_sc)
    );

    amo_alu #(
        .XLEN(XLEN)
    ) alu_i (
        .op       (op_q),
        .old_word (mem_rdata),
        .operand  (opnd_q),
        .result   (alu_result)
    );

    amo_resv resv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (resv_set),
        .clr_i   (resv_clr),
        .valid_o (resv_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and reservation control
    always_comb begin
        state_d  = state_q;
        resv_set = 1'b0;
        resv_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (chk_exc) begin
                        state_d = ST_DONE;
                    end else if (chk_sc) begin
                        if (resv_valid) begin
                            state_d  = ST_WRITE;
                            resv_clr = 1'b1;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_rvalid) begin
                    if (mem_err || op_is_lr) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_WRITE;
                    end
                    resv_set = !mem_err && op_is_lr;
                end
            end
            ST_WRITE: begin
                if (mem_rvalid) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            opnd_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            rd_we_q <= 1'b0;
            exc_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= req_op;
                        addr_q  <= req_addr;
                        opnd_q  <= req_data;
                        wdata_q <= req_data;
                        rd_q    <= '0;
                        rd_we_q <= 1'b0;
                        exc_q   <= 1'b0;
                        cause_q <= CAUSE_NONE;
                        if (chk_exc) begin
                            exc_q   <= 1'b1;
                            cause_q <= chk_cause;
                        end else if (chk_sc && !resv_valid) begin
                            rd_we_q <= 1'b1;
                            rd_q    <= XLEN'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            exc_q   <= 1'b1;
                            cause_q <= op_is_lr ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
                        end else if (op_is_lr) begin
                            rd_we_q <= 1'b1;
                            rd_q    <= mem_rdata;
                        end else begin
                            rd_q    <= mem_rdata;
                            wdata_q <= alu_result;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            exc_q   <= 1'b1;
                            cause_q <= CAUSE_ST_FAULT;
                            rd_we_q <= 1'b0;
                        end else begin
                            rd_we_q <= 1'b1;
                            if (op_q == OP_SC) begin
                                rd_q <= '0;
                            end
                        end
                    end
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy         = state_q != ST_IDLE;
        mem_req      = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we       = state_q == ST_WRITE;
        mem_addr     = addr_q;
        mem_wdata    = wdata_q;
        done_valid   = state_q == ST_DONE;
        done_rd_we   = done_valid && rd_we_q;
        done_rd_data = done_rd_we ? rd_q : '0;
        done_exc     = done_valid && exc_q;
        done_cause   = done_exc ? cause_q : CAUSE_NONE;
    end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [3:0]      req_op,
    input logic [XLEN-1:0] req_addr,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            mem_err,
    input logic            done_valid,
    input logic            done_rd_we,
    input logic [XLEN-1:0] done_rd_data,
    input logic            done_exc,
    input logic            resv_valid
);

    logic start;
    assign start = req_valid && !busy;

    assert_misalign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_op <= OP_MAXU && req_addr[1:0] != 2'b00) |=> (done_valid && done_exc));

    assert_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_op > OP_MAXU) |=> (done_valid && done_exc && !mem_req));

    assert_resv_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resv_valid) |-> $past(mem_rvalid && !mem_err && !mem_we));

    assert_sc_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_op == OP_SC && req_addr[1:0] == 2'b00 && resv_valid) |=> (!resv_valid && mem_req && mem_we));

    assert_sc_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_op == OP_SC && req_addr[1:0] == 2'b00 && !resv_valid)
            |=> (done_valid && done_rd_we && done_rd_data == XLEN'(1)));

    assert_exc_no_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_exc |-> !done_rd_we);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_we_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !done_valid && !resv_valid));

endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_err      (mem_err),
    .done_valid   (done_valid),
    .done_rd_we   (done_rd_we),
    .done_rd_data (done_rd_data),
    .done_exc     (done_exc),
    .resv_valid   (resv_valid)
);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        done_valid;
    logic        done_rd_we;
    logic [31:0] done_rd_data;
    logic        done_exc;
    logic [3:0]  done_cause;
    logic        resv_valid;

    amo_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .done_valid(done_valid), .done_rd_we(done_rd_we), .done_rd_data(done_rd_data),
        .done_exc(done_exc), .done_cause(done_cause),
        .resv_valid(resv_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", checks + 1, fails + 1);
            $finish;
        end
    end

    // Memory model state, touched only by the main process
    logic [31:0] mem_arr [16];
    int lat    = 0;
    int cnt    = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    // Region rules: bit 31 set -> all accesses error; bit 30 set -> writes error
    task automatic tick();
        @(negedge clk);
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_err    = 1'b0;
            cnt        = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_rvalid = 1'b1;
                if (mem_we) begin
                    wr_cnt++;
                    mem_err = mem_addr[31] | mem_addr[30];
                    if (!mem_err) mem_arr[mem_addr[5:2]] = mem_wdata;
                end else begin
                    rd_cnt++;
                    mem_err   = mem_addr[31];
                    mem_rdata = mem_err ? 32'hDEAD_BEEF : mem_arr[mem_addr[5:2]];
                end
            end else begin
                cnt++;
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    logic        g_we;
    logic [31:0] g_rd;
    logic        g_exc;
    logic [3:0]  g_cause;

    task automatic run_op(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] rs2);
        int n;
        rd_cnt = 0;
        wr_cnt = 0;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_data  = rs2;
        tick();
        req_valid = 1'b0;
        n = 0;
        while (!done_valid && n < 100) begin
            tick();
            n++;
        end
        chk("R9", "done seen", {31'd0, done_valid}, 32'd1);
        g_we    = done_rd_we;
        g_rd    = done_rd_data;
        g_exc   = done_exc;
        g_cause = done_cause;
        tick();
        chk("R9", "done one cycle", {31'd0, done_valid}, 32'd0);
    endtask

    function automatic logic [31:0] f_amo(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            2:  return b;
            3:  return a + b;
            4:  return a ^ b;
            5:  return a & b;
            6:  return a | b;
            7:  return ($signed(a) < $signed(b)) ? a : b;
            8:  return ($signed(a) > $signed(b)) ? a : b;
            9:  return (a < b) ? a : b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    logic [31:0] pats [4];
    logic        resv_m = 1'b0;

    initial begin
        pats[0] = 32'h7fff_ffff;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'h0000_0005;
        pats[3] = 32'hffff_ffff;
        for (int i = 0; i < 16; i++) mem_arr[i] = 32'h1000_0000 + i;

        repeat (3) tick();
        // R11: reset state
        chk("R11", "busy", {31'd0, busy}, 32'd0);
        chk("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11", "done_valid", {31'd0, done_valid}, 32'd0);
        chk("R11", "resv", {31'd0, resv_valid}, 32'd0);
        rst_n = 1'b1;
        tick();

        for (int v = 0; v < 4; v++) begin
            for (int a = 0; a < 6; a++) begin
                for (int o = 0; o < 16; o++) begin
                    logic [31:0] addr, rs2, old, e_rd, e_mem;
                    logic        e_we, e_exc, e_resv;
                    logic [3:0]  e_cause;
                    int          e_r, e_w;
                    string       tag;
                    addr = {26'd0, 4'(o), 2'b00};
                    if (a >= 1 && a <= 3) addr[1:0] = 2'(a);
                    if (a == 4) addr[31] = 1'b1;
                    if (a == 5) addr[30] = 1'b1;
                    mem_arr[o] = pats[(v + o + a) % 4] ^ {4'(o), 28'd0};
                    rs2 = pats[v];
                    lat = (v + a + o) % 3;
                    old = mem_arr[o];
                    e_we = 0; e_rd = 0; e_exc = 0; e_cause = 0; e_mem = old;
                    e_resv = resv_m; e_r = 0; e_w = 0;
                    if (o > 10) begin
                        tag = "R2"; e_exc = 1; e_cause = 4'd2;
                    end else if (a >= 1 && a <= 3) begin
                        tag = "R1"; e_exc = 1; e_cause = (o == 0) ? 4'd4 : 4'd6;
                    end else if (o == 0) begin
                        tag = "R3"; e_r = 1;
                        if (a == 4) begin e_exc = 1; e_cause = 4'd5; end
                        else begin e_we = 1; e_rd = old; e_resv = 1; end
                    end else if (o == 1) begin
                        if (!resv_m) begin
                            tag = "R5"; e_we = 1; e_rd = 32'd1;
                        end else begin
                            tag = "R4"; e_resv = 0; e_w = 1;
                            if (a >= 4) begin e_exc = 1; e_cause = 4'd7; end
                            else begin e_we = 1; e_rd = 32'd0; e_mem = rs2; end
                        end
                    end else begin
                        e_r = 1;
                        if (a == 4) begin
                            tag = "R7"; e_exc = 1; e_cause = 4'd7;
                        end else begin
                            e_w = 1;
                            if (a == 5) begin
                                tag = "R8"; e_exc = 1; e_cause = 4'd7;
                            end else begin
                                tag = "R6"; e_we = 1; e_rd = old; e_mem = f_amo(o, old, rs2);
                            end
                        end
                    end
                    run_op(4'(o), addr, rs2);
                    chk(tag, "rd_we", {31'd0, g_we}, {31'd0, e_we});
                    chk(tag, "rd_data", g_rd, e_rd);
                    chk(tag, "exc", {31'd0, g_exc}, {31'd0, e_exc});
                    chk(tag, "cause", {28'd0, g_cause}, {28'd0, e_cause});
                    chk(tag, "memory word", mem_arr[o], e_mem);
                    chk(tag, "reservation", {31'd0, resv_valid}, {31'd0, e_resv});
                    chk("R9", "read count", rd_cnt, e_r);
                    chk("R9", "write count", wr_cnt, e_w);
                    resv_m = e_resv;
                end
            end
        end

        // R10: a request pulsed while busy is ignored
        begin
            int n, dones;
            if (resv_valid) run_op(4'd1, 32'h0000_0004, 32'h0);
            chk("R10", "resv clear before", {31'd0, resv_valid}, 32'd0);
            mem_arr[3] = 32'h0000_0010;
            lat = 3;
            rd_cnt = 0; wr_cnt = 0;
            req_valid = 1'b1; req_op = 4'd3; req_addr = 32'h0000_000C; req_data = 32'h0000_0001;
            tick();
            req_op = 4'd0; req_addr = 32'h0000_0008;
            tick();
            tick();
            req_valid = 1'b0;
            dones = 0;
            for (n = 0; n < 40; n++) begin
                if (done_valid) dones++;
                tick();
            end
            chk("R10", "done count", dones, 1);
            chk("R10", "memory after add", mem_arr[3], 32'h0000_0011);
            chk("R10", "resv untouched", {31'd0, resv_valid}, 32'd0);
            chk("R10", "read count", rd_cnt, 1);
        end

        // R11: reset mid-operation returns the unit to idle with no reservation
        lat = 5;
        run_op(4'd0, 32'h0000_0000, 32'h0);
        req_valid = 1'b1; req_op = 4'd2; req_addr = 32'h0000_0000;
        tick();
        req_valid = 1'b0;
        rst_n = 1'b0;
        tick();
        chk("R11", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R11", "resv after reset", {31'd0, resv_valid}, 32'd0);
        chk("R11", "mem_req after reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        tick();

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule